// File: doc/BRIEF.md
# Audio Sample Rate Detector

This block tells which standard sample rate a recovered digital audio stream carries and reports it as a 4-bit rate code with a one-cycle valid pulse. It runs entirely in the reference-clock domain. A frame strobe from the recovered clock is synchronised, and its rising edges are counted. A 2-bit select names the reference frequency, or it hands the decision to the channel-status bytes instead.

In clock-comparison mode the block counts reference cycles across a window of frame strobes. It then compares the count against midpoint thresholds, which are computed at elaboration time for each reference frequency, and picks the nearest standard rate. In channel-status mode it ignores the strobe. Each time a new status block is flagged, it either copies the consumer rate field or decodes the professional rate fields.

Top module: `audio_rate_detector`

## Requirements
- R1: A synchronous reset sets the rate code to 0001 and holds the valid output low. The first update after reset needs a fresh window or a fresh status block.
- R2: Reference select 00 means 11.2896 MHz, 01 means 12.288 MHz and 10 means 24.576 MHz. A frame rate within ±3% of a standard rate reports that rate's code.
- R3: The rate codes are 44.1k=0000, 48k=0010, 32k=0011, 88.2k=1000, 96k=1010, 176.4k=1100 and 192k=1110. The code 0001 means unknown. In clock-comparison mode no other code is produced.
- R4: A measured rate that lies between two standard rates reports the nearer one. The split point is the arithmetic mean of the two frequencies.
- R5: A measured rate below 24 kHz or above 256 kHz reports 0001.
- R6: With select 11, a professional flag of 0 and a new-block strobe, the code becomes bits 3..0 of status byte 3.
- R7: With select 11, a professional flag of 1 and a new-block strobe, the code is decoded from {byte0[7:6], byte4[6:3]}. The decode is 01/0000→0000, 10/0000→0010, 11/0000→0011, 00/1010→1000, 00/0010→1010, 00/1011→1100 and 00/0011→1110.
- R8: Any professional field combination not listed in R7 reports 0001.
- R9: In clock-comparison mode, if no frame edge arrives for 2^TIMEOUT_LOG2 reference cycles, the code is forced to 0001 without a valid pulse.
- R10: The code changes only when a window completes, when a status block is taken or when a timeout occurs. The first two events raise valid for exactly one cycle, in the same cycle as the new code.
- R11: Frame strobes cause no update while the select is 11. New-block strobes cause no update while the select is 00, 01 or 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| frame_strobe | input | 1 | Frame strobe from the recovered clock, asynchronous |
| ref_sel | input | 2 | Reference frequency select; 11 selects channel-status mode |
| cs_pro | input | 1 | 1 = professional status layout, 0 = consumer |
| cs_new | input | 1 | One-cycle strobe: a new status block is present |
| cs_byte0 | input | 8 | Channel-status byte 0 |
| cs_byte3 | input | 8 | Channel-status byte 3 |
| cs_byte4 | input | 8 | Channel-status byte 4 |
| rate_code | output | 4 | Detected rate code |
| rate_valid | output | 1 | One-cycle pulse on each window or status update |

## Verification
The hardest case to reach is a measured rate close to the split between two neighbouring standard rates. The frame period there must be an integer number of reference cycles on the chosen side of the midpoint, and any transition window must be flushed first. The bench sets exact frame periods in clock cycles on both sides of the 88.2k/96k split. It discards the windows that straddle a period change, and it draws random rates with ±3% deviation on all three references, so that the count lands near but not on the boundaries.

// File: rtl/ard_pkg.sv
package ard_pkg;

   typedef enum logic [3:0] {
      RATE_44K1  = 4'b0000,
      RATE_UNK   = 4'b0001,
      RATE_48K   = 4'b0010,
      RATE_32K   = 4'b0011,
      RATE_88K2  = 4'b1000,
      RATE_96K   = 4'b1010,
      RATE_176K4 = 4'b1100,
      RATE_192K  = 4'b1110
   } rate_e;

   localparam logic [1:0] SEL_STATUS = 2'b11;

   function automatic longint unsigned ref_hz(input int sel);
      case (sel)
         0:       return 64'd11289600;
         1:       return 64'd12288000;
         default: return 64'd24576000;
      endcase
   endfunction

   // Count thresholds, descending: outer low limit, six midpoints, outer high limit.
   function automatic longint unsigned boundary(input longint unsigned fref,
                                                input longint unsigned win,
                                                input int k);
      longint unsigned span;
      span = win * fref;
      case (k)
         0:       return span / 64'd24000;
         1:       return (2 * span) / (64'd32000 + 64'd44100);
         2:       return (2 * span) / (64'd44100 + 64'd48000);
         3:       return (2 * span) / (64'd48000 + 64'd88200);
         4:       return (2 * span) / (64'd88200 + 64'd96000);
         5:       return (2 * span) / (64'd96000 + 64'd176400);
         6:       return (2 * span) / (64'd176400 + 64'd192000);
         default: return span / 64'd256000;
      endcase
   endfunction

   function automatic int count_width(input longint unsigned win);
      return $clog2(win * 64'd24576000 / 64'd24000 + 64'd1) + 1;
   endfunction

endpackage

// File: rtl/ard_sync_edge.sv
module ard_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic async_in,
   output logic rise
);
   logic [STAGES-1:0] chain;
   logic              last;

   initial begin
      if (STAGES < 2) $error("ard_sync_edge: STAGES must be at least 2");
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         chain <= '0;
         last  <= 1'b0;
      end else begin
         chain <= {chain[STAGES-2:0], async_in};
         last  <= chain[STAGES-1];
      end
   end

   assign rise = chain[STAGES-1] & ~last;
endmodule

// File: rtl/ard_window_counter.sv
module ard_window_counter #(
   parameter int WINDOW_FRAMES = 64,
   parameter int CNT_W         = 18,
   parameter int TIMEOUT_LOG2  = 20
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             enable,
   input  logic             edge_in,
   output logic             done,
   output logic [CNT_W-1:0] count,
   output logic             timeout
);
   localparam int FW = (WINDOW_FRAMES > 2) ? $clog2(WINDOW_FRAMES) : 1;
   localparam logic [FW-1:0]           LAST_FRAME = FW'(WINDOW_FRAMES - 1);
   localparam logic [CNT_W-1:0]        CNT_MAX    = '1;
   localparam logic [TIMEOUT_LOG2-1:0] IDLE_MAX   = '1;

   logic                    armed;
   logic [FW-1:0]           frames;
   logic [CNT_W-1:0]        cycles;
   logic [TIMEOUT_LOG2-1:0] idle;
   logic [CNT_W-1:0]        cycles_inc;

   assign cycles_inc = (cycles == CNT_MAX) ? CNT_MAX : cycles + 1'b1;

   always_ff @(posedge clk) begin
      done    <= 1'b0;
      timeout <= 1'b0;
      if (rst || !enable) begin
         armed  <= 1'b0;
         frames <= '0;
         cycles <= '0;
         idle   <= '0;
         if (rst) count <= '0;
      end else begin
         if (edge_in) begin
            idle <= '0;
         end else if (idle == IDLE_MAX - 1'b1) begin
            idle    <= IDLE_MAX;
            timeout <= 1'b1;
            armed   <= 1'b0;
         end else if (idle != IDLE_MAX) begin
            idle <= idle + 1'b1;
         end

         if (edge_in) begin
            if (!armed) begin
               armed  <= 1'b1;
               frames <= '0;
               cycles <= '0;
            end else if (frames == LAST_FRAME) begin
               done   <= 1'b1;
               count  <= cycles_inc;
               frames <= '0;
               cycles <= '0;
            end else begin
               frames <= frames + 1'b1;
               cycles <= cycles_inc;
            end
         end else if (armed) begin
            cycles <= cycles_inc;
         end
      end
   end
endmodule

// File: rtl/ard_classifier.sv
module ard_classifier #(
   parameter longint unsigned FREF_HZ       = 64'd11289600,
   parameter int              WINDOW_FRAMES = 64,
   parameter int              CNT_W         = 18
) (
   input  logic [CNT_W-1:0] count,
   output logic [3:0]       code
);
   import ard_pkg::*;

   logic [7:0] above;

   for (genvar k = 0; k < 8; k++) begin : g_th
      localparam longint unsigned TH = boundary(FREF_HZ, longint'(WINDOW_FRAMES), k);
      if (k == 7) begin : g_hi
         assign above[k] = (count >= TH[CNT_W-1:0]);
      end else begin : g_mid
         assign above[k] = (count > TH[CNT_W-1:0]);
      end
   end

   always_comb begin
      if (above[0])      code = RATE_UNK;
      else if (above[1]) code = RATE_32K;
      else if (above[2]) code = RATE_44K1;
      else if (above[3]) code = RATE_48K;
      else if (above[4]) code = RATE_88K2;
      else if (above[5]) code = RATE_96K;
      else if (above[6]) code = RATE_176K4;
      else if (above[7]) code = RATE_192K;
      else               code = RATE_UNK;
   end
endmodule

// File: rtl/ard_status_decoder.sv
module ard_status_decoder (
   input  logic       pro,
   input  logic [7:0] byte0,
   input  logic [7:0] byte3,
   input  logic [7:0] byte4,
   output logic [3:0] code
);
   import ard_pkg::*;

   logic [5:0] pro_key;
   logic [3:0] pro_code;

   assign pro_key = {byte0[7:6], byte4[6:3]};

   always_comb begin
      case (pro_key)
         6'b01_0000: pro_code = RATE_44K1;
         6'b10_0000: pro_code = RATE_48K;
         6'b11_0000: pro_code = RATE_32K;
         6'b00_1010: pro_code = RATE_88K2;
         6'b00_0010: pro_code = RATE_96K;
         6'b00_1011: pro_code = RATE_176K4;
         6'b00_0011: pro_code = RATE_192K;
         default:    pro_code = RATE_UNK;
      endcase
   end

   assign code = pro ? pro_code : byte3[3:0];
endmodule

// File: rtl/audio_rate_detector.sv
module audio_rate_detector #(
   parameter int WINDOW_FRAMES = 64,
   parameter int TIMEOUT_LOG2  = 20,
   parameter int SYNC_STAGES   = 2
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       frame_strobe,
   input  logic [1:0] ref_sel,
   input  logic       cs_pro,
   input  logic       cs_new,
   input  logic [7:0] cs_byte0,
   input  logic [7:0] cs_byte3,
   input  logic [7:0] cs_byte4,
   output logic [3:0] rate_code,
   output logic       rate_valid
);
   import ard_pkg::*;

   localparam int CNT_W = count_width(longint'(WINDOW_FRAMES));
   localparam int N_REF = 3;

   initial begin
      if (WINDOW_FRAMES < 2) $error("audio_rate_detector: WINDOW_FRAMES must be at least 2");
      if (TIMEOUT_LOG2 < 4)  $error("audio_rate_detector: TIMEOUT_LOG2 too small");
   end

   logic             edge_seen;
   logic [1:0]       sel_q;
   logic             meas_en;
   logic             win_done;
   logic             win_timeout;
   logic [CNT_W-1:0] win_count;
   logic [3:0]       ref_code [N_REF];
   logic [3:0]       clk_code;
   logic [3:0]       cs_code;

   ard_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst      (rst),
      .async_in (frame_strobe),
      .rise     (edge_seen)
   );

   always_ff @(posedge clk) begin
      if (rst) sel_q <= SEL_STATUS;
      else     sel_q <= ref_sel;
   end

   // A changed select restarts the window so no count mixes two references.
   assign meas_en = (ref_sel != SEL_STATUS) && (ref_sel == sel_q);

   ard_window_counter #(
      .WINDOW_FRAMES (WINDOW_FRAMES),
      .CNT_W         (CNT_W),
      .TIMEOUT_LOG2  (TIMEOUT_LOG2)
   ) u_win (
      .clk     (clk),
      .rst     (rst),
      .enable  (meas_en),
      .edge_in (edge_seen),
      .done    (win_done),
      .count   (win_count),
      .timeout (win_timeout)
   );

   for (genvar g = 0; g < N_REF; g++) begin : g_ref
      ard_classifier #(
         .FREF_HZ       (ref_hz(g)),
         .WINDOW_FRAMES (WINDOW_FRAMES),
         .CNT_W         (CNT_W)
      ) u_cls (
         .count (win_count),
         .code  (ref_code[g])
      );
   end

   always_comb begin
      case (sel_q)
         2'b00:   clk_code = ref_code[0];
         2'b01:   clk_code = ref_code[1];
         2'b10:   clk_code = ref_code[2];
         default: clk_code = RATE_UNK;
      endcase
   end

   ard_status_decoder u_cs (
      .pro   (cs_pro),
      .byte0 (cs_byte0),
      .byte3 (cs_byte3),
      .byte4 (cs_byte4),
      .code  (cs_code)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         rate_code  <= RATE_UNK;
         rate_valid <= 1'b0;
      end else begin
         rate_valid <= 1'b0;
         if (cs_new && ref_sel == SEL_STATUS) begin
            rate_code  <= cs_code;
            rate_valid <= 1'b1;
         end else if (win_done) begin
            rate_code  <= clk_code;
            rate_valid <= 1'b1;
         end else if (win_timeout) begin
            rate_code  <= RATE_UNK;
         end
      end
   end
endmodule

// File: rtl/audio_rate_detector_chk.sv
module audio_rate_detector_chk (
   input logic       clk,
   input logic       rst,
   input logic [1:0] ref_sel,
   input logic       cs_pro,
   input logic       cs_new,
   input logic [7:0] cs_byte0,
   input logic [7:0] cs_byte3,
   input logic [7:0] cs_byte4,
   input logic [3:0] rate_code,
   input logic       rate_valid
);
   assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (rate_code == 4'b0001 && !rate_valid));

   assert_legal_code_R3: assert property (@(posedge clk) disable iff (rst)
      (rate_valid && !$past(rst) && !$past(cs_new && ref_sel == 2'b11)) |->
      (rate_code inside {4'b0000, 4'b0001, 4'b0010, 4'b0011,
                         4'b1000, 4'b1010, 4'b1100, 4'b1110}));

   assert_consumer_copy_R6: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(cs_new && ref_sel == 2'b11 && !cs_pro)) |->
      (rate_valid && rate_code == $past(cs_byte3[3:0])));

   assert_pro_fallback_R8: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(cs_new && ref_sel == 2'b11 && cs_pro && cs_byte4[6:3] == 4'b0001)) |->
      (rate_valid && rate_code == 4'b0001));

   assert_code_hold_R10: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$stable(rate_code)) |-> (rate_valid || rate_code == 4'b0001));

   // cs_byte0 is unused by the properties above beyond decode; kept for completeness of the bind.
   logic unused_ok;
   assign unused_ok = ^cs_byte0;
endmodule

bind audio_rate_detector audio_rate_detector_chk u_chk (
   .clk        (clk),
   .rst        (rst),
   .ref_sel    (ref_sel),
   .cs_pro     (cs_pro),
   .cs_new     (cs_new),
   .cs_byte0   (cs_byte0),
   .cs_byte3   (cs_byte3),
   .cs_byte4   (cs_byte4),
   .rate_code  (rate_code),
   .rate_valid (rate_valid)
);

// File: tb/sim_audio_rate_detector.sv
module sim_audio_rate_detector;
   localparam int W   = 2;
   localparam int TOL = 12;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       frame_strobe = 1'b0;
   logic [1:0] ref_sel = 2'b11;
   logic       cs_pro = 1'b0;
   logic       cs_new = 1'b0;
   logic [7:0] cs_byte0 = '0, cs_byte3 = '0, cs_byte4 = '0;
   logic [3:0] rate_code;
   logic       rate_valid;

   int  errors = 0;
   int  checks = 0;
   int  period = 256;
   bit  strobe_on = 1'b0;
   bit  done_flag = 1'b0;

   always #2 clk = ~clk;

   audio_rate_detector #(.WINDOW_FRAMES(W), .TIMEOUT_LOG2(TOL)) u0 (
      .clk(clk), .rst(rst), .frame_strobe(frame_strobe), .ref_sel(ref_sel),
      .cs_pro(cs_pro), .cs_new(cs_new), .cs_byte0(cs_byte0), .cs_byte3(cs_byte3),
      .cs_byte4(cs_byte4), .rate_code(rate_code), .rate_valid(rate_valid));

   function automatic real fref_of(input int s);
      case (s)
         0:       return 11289600.0;
         1:       return 12288000.0;
         default: return 24576000.0;
      endcase
   endfunction

   function automatic real rate_hz(input int i);
      case (i)
         0: return 32000.0;  1: return 44100.0;  2: return 48000.0;
         3: return 88200.0;  4: return 96000.0;  5: return 176400.0;
         default: return 192000.0;
      endcase
   endfunction

   function automatic logic [3:0] rate_enc(input int i);
      case (i)
         0: return 4'b0011; 1: return 4'b0000; 2: return 4'b0010;
         3: return 4'b1000; 4: return 4'b1010; 5: return 4'b1100;
         default: return 4'b1110;
      endcase
   endfunction

   function automatic logic [3:0] nearest(input real f);
      int  best = 0;
      real d;
      if (f < 24000.0 || f > 256000.0) return 4'b0001;
      for (int i = 1; i < 7; i++) begin
         d = (f > rate_hz(i)) ? f - rate_hz(i) : rate_hz(i) - f;
         if (d < ((f > rate_hz(best)) ? f - rate_hz(best) : rate_hz(best) - f)) best = i;
      end
      return rate_enc(best);
   endfunction

   function automatic logic [3:0] pro_expect(input logic [1:0] a, input logic [3:0] b);
      case ({a, b})
         6'b01_0000: return 4'b0000;
         6'b10_0000: return 4'b0010;
         6'b11_0000: return 4'b0011;
         6'b00_1010: return 4'b1000;
         6'b00_0010: return 4'b1010;
         6'b00_1011: return 4'b1100;
         6'b00_0011: return 4'b1110;
         default:    return 4'b0001;
      endcase
   endfunction

   task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%b expected=%b", req, act, exp);
      end
   endtask

   initial begin : strobe_gen
      forever begin
         if (!strobe_on) begin
            frame_strobe = 1'b0;
            @(negedge clk);
         end else begin
            automatic int p = period;
            frame_strobe = 1'b1;
            repeat (p / 2) @(negedge clk);
            frame_strobe = 1'b0;
            repeat (p - p / 2) @(negedge clk);
         end
      end
   end

   task automatic wait_valid(output bit got);
      got = 1'b0;
      for (int i = 0; i < 20000; i++) begin
         @(negedge clk);
         if (rate_valid) begin got = 1'b1; break; end
      end
   endtask

   task automatic measure(input int sel, input int p, input logic [3:0] exp, input string req);
      bit got;
      ref_sel = sel[1:0];
      period = p;
      strobe_on = 1'b1;
      wait_valid(got);
      wait_valid(got);
      wait_valid(got);
      check(req, got ? rate_code : 4'bxxxx, exp);
   endtask

   task automatic cs_block(input bit pro, input logic [7:0] b0, input logic [7:0] b3,
                           input logic [7:0] b4);
      @(negedge clk);
      cs_pro = pro; cs_byte0 = b0; cs_byte3 = b3; cs_byte4 = b4; cs_new = 1'b1;
      @(negedge clk);
      cs_new = 1'b0;
   endtask

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      if (!done_flag) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin : stim
      int vcount;
      void'($urandom(32'd4711));
      repeat (5) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      check("R1 reset code", rate_code, 4'b0001);
      check("R1 reset valid", {3'b0, rate_valid}, 4'b0000);

      // R2 / R3 directed exact rates on each reference
      measure(0, 256, 4'b0000, "R2 R3 sel00 44.1k");
      measure(1, 256, 4'b0010, "R2 R3 sel01 48k");
      measure(2, 128, 4'b1110, "R2 R3 sel10 192k");
      measure(2, 768, 4'b0011, "R3 sel10 32k");

      // R4 near the 88.2k/96k split (about 92.1k at 24.576 MHz: 266.8 cycles)
      measure(2, 262, nearest(24576000.0 / 262.0), "R4 just above split");
      measure(2, 272, nearest(24576000.0 / 272.0), "R4 just below split");

      // R5 out of range
      measure(2, 1229, 4'b0001, "R5 below 24k");
      measure(0, 38, 4'b0001, "R5 above 256k");

      // R2 randomised within +/-3%
      for (int n = 0; n < 12; n++) begin
         automatic int s   = int'($urandom % 3);
         automatic int idx = int'($urandom % 7);
         automatic int dev = int'($urandom % 61) - 30;
         automatic real pr = fref_of(s) / (rate_hz(idx) * (1.0 + dev / 1000.0));
         automatic int  p  = $rtoi(pr + 0.5);
         measure(s, p, rate_enc(idx), "R2 random +/-3%");
      end

      // R11: status strobe ignored in clock mode; R10 code held
      measure(2, 128, 4'b1110, "R10 setup 192k");
      cs_block(1'b0, 8'h00, 8'h05, 8'h00);
      check("R11 cs_new ignored valid", {3'b0, rate_valid}, 4'b0000);
      check("R11 cs_new ignored code", rate_code, 4'b1110);

      // R9 timeout
      strobe_on = 1'b0;
      vcount = 0;
      for (int i = 0; i < (1 << TOL) + 300; i++) begin
         @(negedge clk);
         if (rate_valid) vcount++;
      end
      check("R9 timeout code", rate_code, 4'b0001);
      check("R9 timeout no valid", vcount[3:0], 4'd0);

      // R11: strobes ignored in status mode
      ref_sel = 2'b11;
      period = 128;
      strobe_on = 1'b1;
      repeat (10) @(negedge clk);
      vcount = 0;
      for (int i = 0; i < 1500; i++) begin
         @(negedge clk);
         if (rate_valid) vcount++;
      end
      check("R11 strobes ignored in status mode", vcount[3:0], 4'd0);
      strobe_on = 1'b0;

      // R6 consumer copy, R10 one-cycle valid
      for (int n = 0; n < 6; n++) begin
         automatic logic [7:0] b3 = 8'($urandom);
         cs_block(1'b0, 8'($urandom), b3, 8'($urandom));
         check("R6 consumer copy", rate_code, b3[3:0]);
         check("R10 valid with status update", {3'b0, rate_valid}, 4'b0001);
         @(negedge clk);
         check("R10 valid one cycle", {3'b0, rate_valid}, 4'b0000);
         check("R10 code held", rate_code, b3[3:0]);
      end

      // R7 professional table
      begin
         logic [1:0] pa [7] = '{2'b01, 2'b10, 2'b11, 2'b00, 2'b00, 2'b00, 2'b00};
         logic [3:0] pb [7] = '{4'b0000, 4'b0000, 4'b0000, 4'b1010, 4'b0010, 4'b1011, 4'b0011};
         logic [3:0] pe [7] = '{4'b0000, 4'b0010, 4'b0011, 4'b1000, 4'b1010, 4'b1100, 4'b1110};
         for (int i = 0; i < 7; i++) begin
            cs_block(1'b1, {pa[i], 6'($urandom)}, 8'h0F, {1'($urandom), pb[i], 3'($urandom)});
            check("R7 professional decode", rate_code, pe[i]);
         end
      end

      // R8 professional fallback: directed and random
      cs_block(1'b1, 8'h40, 8'h00, {1'b0, 4'b1010, 3'b000});
      check("R8 pro 01/1010 unknown", rate_code, 4'b0001);
      cs_block(1'b1, 8'h00, 8'h00, 8'h00);
      check("R8 pro 00/0000 unknown", rate_code, 4'b0001);
      for (int n = 0; n < 10; n++) begin
         automatic logic [7:0] b0 = 8'($urandom);
         automatic logic [7:0] b4 = 8'($urandom);
         cs_block(1'b1, b0, 8'($urandom), b4);
         check("R7 R8 pro random", rate_code, pro_expect(b0[7:6], b4[6:3]));
      end

      // R1 reset mid-run
      cs_block(1'b1, 8'h80, 8'h00, 8'h00);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      check("R1 reset mid-run code", rate_code, 4'b0001);
      check("R1 reset mid-run valid", {3'b0, rate_valid}, 4'b0000);

      done_flag = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule